// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of 2-bit saturating counters. The table is addressed by XORing the word-aligned fetch PC with a global register that records recent branch outcomes. The history is placed above the three lowest index bits, so those bits always come from the PC alone. Nearby branches therefore keep separate entries whatever the path history is.

The fetch side presents a PC on the lookup port. One cycle later the block returns the predicted direction, the counter value it read, and the history snapshot that formed the index. At the same clock edge as the lookup, the history shifts in the predicted direction. The back end later returns the PC, the snapshot and the resolved outcome on the update port, and the block trains that entry. A flag on the update port marks a misprediction. It reloads the history from the snapshot, with the true outcome appended.

The index width is a parameter, and the history width is derived from it. Setting the index to 14 bits gives a 16K-entry table with an 11-bit history. The default setting is smaller.

Top module: `gshare_predictor`

## Requirements
- R1: After reset every counter holds 01 (weakly not-taken), the global history is all zeros and `pred_valid` is low. A first lookup of any PC returns counter 01, not-taken and history 0.
- R2: A lookup presented in cycle N gives `pred_valid` high in cycle N+1 only. In a cycle with no lookup, `pred_valid` is low and `pred_taken`, `pred_ctr` and `pred_hist` keep their values.
- R3: The table index is PC[IDX_W+1:2] XOR (history << 3). PC[1:0] and the PC bits above the index do not affect the index.
- R4: Index bits [2:0] depend only on PC[4:2]. The history changes only index bits [IDX_W-1:3].
- R5: On an update, the addressed counter increments when taken and decrements when not taken. It saturates at 3 and at 0.
- R6: `pred_taken` equals bit 1 of the counter read, and `pred_ctr` reports that counter.
- R7: On a lookup without a same-cycle repair, the history becomes {history[HIST_W-2:0], predicted direction}.
- R8: An update with the mispredict flag set loads the history with {upd_hist[HIST_W-2:0], upd_taken}. This takes priority over a same-cycle lookup shift.
- R9: An update without the mispredict flag leaves the history unchanged.
- R10: When an update and a lookup address the same entry in one cycle, the lookup returns the counter value after the update.
- R11: `pred_hist` returns the history value that formed the lookup's index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | Fetch PC of the branch to predict |
| upd_valid | input | 1 | Training request for a resolved branch |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_hist | input | HIST_W | History snapshot returned with that branch's prediction |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_mispred | input | 1 | Resolved direction differed from the prediction; repair the history |
| pred_valid | output | 1 | Prediction result valid (one cycle after lookup) |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_ctr | output | 2 | Counter value that produced the prediction |
| pred_hist | output | HIST_W | History snapshot that formed the lookup index |

## Verification
The assertions check the timing and history rules on every cycle. They cover the one-cycle lookup latency, result holding when idle, the speculative shift, the repair and its priority, history holding on a plain update, and the returned snapshot. Which counter a given PC and history reach depends on table contents, so only the bench's scenarios show it. The scenarios cover the XOR hash and the PC-only low bits, saturation at both ends, the reset value and same-cycle update forwarding. They compare each returned counter against a reference table held in the bench.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

  typedef enum logic [1:0] {
    CTR_STRONG_NT = 2'b00,
    CTR_WEAK_NT   = 2'b01,
    CTR_WEAK_T    = 2'b10,
    CTR_STRONG_T  = 2'b11
  } ctr_e;

  localparam logic [1:0] CTR_RESET = CTR_WEAK_NT;

  // Saturating up/down step of a 2-bit counter.
  function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
    logic [1:0] nxt;
    if (taken) nxt = (cur == CTR_STRONG_T)  ? cur : cur + 2'd1;
    else       nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/gshare_rst_sync.sv
module gshare_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_out = sync_q;
endmodule

// File: rtl/gshare_index.sv
module gshare_index #(
  parameter int IDX_W   = 10,
  parameter int PC_ONLY = 3,
  localparam int HIST_W = IDX_W - PC_ONLY
) (
  input  logic [IDX_W-1:0]  pc_slice,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  idx
);
  generate
    if (PC_ONLY == 0) begin : g_full_mix
      assign idx = pc_slice ^ hist;
    end else begin : g_offset_mix
      // Low PC_ONLY bits pass straight through; history mixes above them.
      assign idx[PC_ONLY-1:0]     = pc_slice[PC_ONLY-1:0];
      assign idx[IDX_W-1:PC_ONLY] = pc_slice[IDX_W-1:PC_ONLY] ^ hist;
    end
  endgenerate
endmodule

// File: rtl/gshare_ctr_table.sv
module gshare_ctr_table
  import gshare_pkg::*;
#(
  parameter int IDX_W = 10,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_ctr
);
  logic [1:0] tbl_q [DEPTH];
  logic [1:0] wr_val;

  // Next-state of the trained entry.
  always_comb begin
    wr_val = ctr_step(tbl_q[wr_idx], wr_taken);
  end

  // Read with same-cycle write forwarding: the update is applied first.
  always_comb begin
    if (wr_en && (wr_idx == rd_idx)) rd_ctr = wr_val;
    else                             rd_ctr = tbl_q[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl_q[i] <= CTR_RESET;
    end else if (wr_en) begin
      tbl_q[wr_idx] <= wr_val;
    end
  end
endmodule

// File: rtl/gshare_ghr.sv
module gshare_ghr #(
  parameter int HIST_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_bit,
  input  logic              repair_en,
  input  logic [HIST_W-2:0] repair_lo,
  input  logic              repair_bit,
  output logic [HIST_W-1:0] hist_q
);
  logic [HIST_W-1:0] hist_d;

  always_comb begin
    if (repair_en)     hist_d = {repair_lo, repair_bit};
    else if (shift_en) hist_d = {hist_q[HIST_W-2:0], shift_bit};
    else               hist_d = hist_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end
endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor #(
  parameter int PC_W          = 32,
  parameter int PC_LSB        = 2,
  parameter int IDX_W         = 10,
  parameter int PC_ONLY_BITS  = 3,
  localparam int HIST_W       = IDX_W - PC_ONLY_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic [HIST_W-1:0] upd_hist,
  input  logic              upd_taken,
  input  logic              upd_mispred,
  output logic              pred_valid,
  output logic              pred_taken,
  output logic [1:0]        pred_ctr,
  output logic [HIST_W-1:0] pred_hist
);
  localparam int PC_TOP = PC_LSB + IDX_W;

  logic              rst_sync_n;
  logic [HIST_W-1:0] ghr_q;
  logic [IDX_W-1:0]  lk_idx;
  logic [IDX_W-1:0]  upd_idx;
  logic [1:0]        rd_ctr;
  logic              repair_en;

  logic              pred_valid_q, pred_valid_d;
  logic              pred_taken_q, pred_taken_d;
  logic [1:0]        pred_ctr_q,   pred_ctr_d;
  logic [HIST_W-1:0] pred_hist_q,  pred_hist_d;

  logic unused_pc_bits;
  assign unused_pc_bits = ^{lk_pc[PC_W-1:PC_TOP], lk_pc[PC_LSB-1:0],
                            upd_pc[PC_W-1:PC_TOP], upd_pc[PC_LSB-1:0]};

  gshare_rst_sync rst_sync_i (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  gshare_index #(.IDX_W(IDX_W), .PC_ONLY(PC_ONLY_BITS)) lk_hash_i (
    .pc_slice (lk_pc[PC_TOP-1:PC_LSB]),
    .hist     (ghr_q),
    .idx      (lk_idx)
  );

  gshare_index #(.IDX_W(IDX_W), .PC_ONLY(PC_ONLY_BITS)) upd_hash_i (
    .pc_slice (upd_pc[PC_TOP-1:PC_LSB]),
    .hist     (upd_hist),
    .idx      (upd_idx)
  );

  gshare_ctr_table #(.IDX_W(IDX_W)) table_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (upd_valid),
    .wr_idx   (upd_idx),
    .wr_taken (upd_taken),
    .rd_idx   (lk_idx),
    .rd_ctr   (rd_ctr)
  );

  assign repair_en = upd_valid && upd_mispred;

  gshare_ghr #(.HIST_W(HIST_W)) ghr_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .shift_en   (lk_valid),
    .shift_bit  (rd_ctr[1]),
    .repair_en  (repair_en),
    .repair_lo  (upd_hist[HIST_W-2:0]),
    .repair_bit (upd_taken),
    .hist_q     (ghr_q)
  );

  // Result stage: loads on a lookup, holds otherwise.
  always_comb begin
    pred_valid_d = lk_valid;
    pred_taken_d = pred_taken_q;
    pred_ctr_d   = pred_ctr_q;
    pred_hist_d  = pred_hist_q;
    if (lk_valid) begin
      pred_taken_d = rd_ctr[1];
      pred_ctr_d   = rd_ctr;
      pred_hist_d  = ghr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pred_valid_q <= 1'b0;
      pred_taken_q <= 1'b0;
      pred_ctr_q   <= 2'b00;
      pred_hist_q  <= '0;
    end else begin
      pred_valid_q <= pred_valid_d;
      pred_taken_q <= pred_taken_d;
      pred_ctr_q   <= pred_ctr_d;
      pred_hist_q  <= pred_hist_d;
    end
  end

  assign pred_valid = pred_valid_q;
  assign pred_taken = pred_taken_q;
  assign pred_ctr   = pred_ctr_q;
  assign pred_hist  = pred_hist_q;
endmodule

// File: rtl/gshare_predictor_chk.sv
module gshare_predictor_chk #(
  parameter int HIST_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              upd_valid,
  input logic [HIST_W-1:0] upd_hist,
  input logic              upd_taken,
  input logic              upd_mispred,
  input logic              pred_valid,
  input logic              pred_taken,
  input logic [1:0]        pred_ctr,
  input logic [HIST_W-1:0] pred_hist,
  input logic [HIST_W-1:0] hist_q
);

  assert_lookup_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> pred_valid);

  assert_idle_no_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !pred_valid);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> ($stable(pred_taken) && $stable(pred_ctr) && $stable(pred_hist)));

  assert_taken_from_msb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |-> (pred_taken == pred_ctr[1]));

  assert_spec_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !(upd_valid && upd_mispred))
      |=> (hist_q == {$past(hist_q[HIST_W-2:0]), pred_taken}));

  assert_repair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_mispred)
      |=> (hist_q == {$past(upd_hist[HIST_W-2:0]), $past(upd_taken)}));

  assert_hist_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!lk_valid && !(upd_valid && upd_mispred)) |=> $stable(hist_q));

  assert_snapshot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (pred_hist == $past(hist_q)));

endmodule

bind gshare_predictor gshare_predictor_chk #(.HIST_W(HIST_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .lk_valid    (lk_valid),
  .upd_valid   (upd_valid),
  .upd_hist    (upd_hist),
  .upd_taken   (upd_taken),
  .upd_mispred (upd_mispred),
  .pred_valid  (pred_valid),
  .pred_taken  (pred_taken),
  .pred_ctr    (pred_ctr),
  .pred_hist   (pred_hist),
  .hist_q      (ghr_q)
);

// File: tb/gshare_predictor_tb_top.sv
module gshare_predictor_tb_top;
  localparam int IDX_W  = 10;
  localparam int HIST_W = 7;
  localparam int DEPTH  = 1 << IDX_W;

  logic              clk;
  logic              rst_n;
  logic              lk_valid;
  logic [31:0]       lk_pc;
  logic              upd_valid;
  logic [31:0]       upd_pc;
  logic [HIST_W-1:0] upd_hist;
  logic              upd_taken;
  logic              upd_mispred;
  logic              pred_valid;
  logic              pred_taken;
  logic [1:0]        pred_ctr;
  logic [HIST_W-1:0] pred_hist;

  int n_tests;
  int n_fail;
  bit done;

  // Reference state built from the requirements.
  logic [1:0]        ref_tbl [DEPTH];
  logic [HIST_W-1:0] ref_hist;
  logic [1:0]        last_ctr;
  logic              last_taken;
  logic [HIST_W-1:0] last_hist;

  gshare_predictor dut_i (
    .clk (clk), .rst_n (rst_n),
    .lk_valid (lk_valid), .lk_pc (lk_pc),
    .upd_valid (upd_valid), .upd_pc (upd_pc), .upd_hist (upd_hist),
    .upd_taken (upd_taken), .upd_mispred (upd_mispred),
    .pred_valid (pred_valid), .pred_taken (pred_taken),
    .pred_ctr (pred_ctr), .pred_hist (pred_hist)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [IDX_W-1:0] f_idx(input logic [31:0] pc, input logic [HIST_W-1:0] h);
    return pc[2 +: IDX_W] ^ {h, 3'b000};
  endfunction

  function automatic logic [1:0] f_step(input logic [1:0] c, input logic t);
    if (t) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  // One cycle of stimulus, model update, and check of the result.
  task automatic step(input string tag, input bit lv, input logic [31:0] lpc,
                      input bit uv, input logic [31:0] upc, input logic [HIST_W-1:0] uh,
                      input bit ut, input bit um);
    logic [1:0]        e_ctr;
    logic              e_taken;
    logic [HIST_W-1:0] e_hist;
    logic [IDX_W-1:0]  li;
    @(negedge clk);
    lk_valid = lv; lk_pc = lpc;
    upd_valid = uv; upd_pc = upc; upd_hist = uh; upd_taken = ut; upd_mispred = um;
    li = f_idx(lpc, ref_hist);
    if (uv) ref_tbl[f_idx(upc, uh)] = f_step(ref_tbl[f_idx(upc, uh)], ut);
    if (lv) begin
      e_ctr = ref_tbl[li]; e_taken = e_ctr[1]; e_hist = ref_hist;
    end else begin
      e_ctr = last_ctr; e_taken = last_taken; e_hist = last_hist;
    end
    if (uv && um)  ref_hist = {uh[HIST_W-2:0], ut};
    else if (lv)   ref_hist = {ref_hist[HIST_W-2:0], e_taken};
    @(posedge clk);
    #1;
    n_tests++;
    if (pred_valid !== lv || pred_ctr !== e_ctr || pred_taken !== e_taken || pred_hist !== e_hist) begin
      n_fail++;
      $display("FAIL %s: valid/ctr/taken/hist got %0b/%0d/%0b/%h expected %0b/%0d/%0b/%h",
               tag, pred_valid, pred_ctr, pred_taken, pred_hist, lv, e_ctr, e_taken, e_hist);
    end
    last_ctr = e_ctr; last_taken = e_taken; last_hist = e_hist;
    lk_valid = 1'b0; upd_valid = 1'b0; upd_mispred = 1'b0;
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 32'h0, 0, 32'h0, '0, 0, 0);
  endtask

  task automatic lookup(input string tag, input logic [31:0] pc);
    step(tag, 1, pc, 0, 32'h0, '0, 0, 0);
  endtask

  task automatic train(input string tag, input logic [31:0] pc, input logic [HIST_W-1:0] h, input bit t);
    step(tag, 0, 32'h0, 1, pc, h, t, 0);
  endtask

  // Loads the history with target through a mispredict repair (R8).
  task automatic set_hist(input string tag, input logic [HIST_W-1:0] target);
    step(tag, 0, 32'h0, 1, 32'hFFF0_0000, {1'b0, target[HIST_W-1:1]}, target[0], 1);
  endtask

  task automatic t_reset();
    n_tests++;
    if (pred_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: pred_valid after reset got %0b expected 0", pred_valid);
    end
    lookup("R1 first lookup weak not-taken", 32'h0000_1234);
    lookup("R1 second untouched entry", 32'h0000_8ABC);
  endtask

  task automatic t_latency();
    idle("R2 idle before lookup");
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = 32'h0000_0400;
    #1;
    n_tests++;
    if (pred_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R2: pred_valid same cycle got %0b expected 0", pred_valid);
    end
    lk_valid = 1'b0;
    idle("R2 no lookup, result held");
    lookup("R2 lookup after idle", 32'h0000_0404);
    idle("R2 valid drops after one cycle");
  endtask

  task automatic t_saturate();
    set_hist("R8 set history", 7'h2A);
    for (int i = 0; i < 4; i++) train("R9 train taken, history held", 32'h0000_2000, 7'h2A, 1);
    lookup("R5 R6 saturated at 3 predicts taken", 32'h0000_2000);
    set_hist("R8 set history", 7'h2A);
    for (int i = 0; i < 5; i++) train("R9 train not-taken, history held", 32'h0000_2000, 7'h2A, 0);
    lookup("R5 R6 saturated at 0 predicts not-taken", 32'h0000_2000);
    set_hist("R8 set history", 7'h2A);
    train("R5 step up from 0", 32'h0000_2000, 7'h2A, 1);
    lookup("R5 counter at 1 after one increment", 32'h0000_2000);
  endtask

  task automatic t_hash();
    // Train entry for pc 0x3000 under history 0x55; index = 0x00 ^ 0x2A8 = 0x2A8.
    set_hist("R8 set history", 7'h55);
    train("R3 train under history", 32'h0000_3000, 7'h55, 1);
    train("R3 train under history", 32'h0000_3000, 7'h55, 1);
    set_hist("R8 clear history", 7'h00);
    lookup("R3 aliased pc reaches XOR index 0x2A8", 32'h0000_0AA0);
    set_hist("R8 clear history", 7'h00);
    lookup("R3 PC[1:0] ignored", 32'h0000_0AA3);
    set_hist("R8 clear history", 7'h00);
    lookup("R3 PC bits above index ignored", 32'h7000_0AA0);
    set_hist("R8 history flips bit 0", 7'h01);
    lookup("R4 history moves index bit 3 only", 32'h0000_0AA0);
    set_hist("R8 history all ones", 7'h7F);
    lookup("R4 low index bits from PC under full history", 32'h0000_0AAC);
  endtask

  task automatic t_spec();
    set_hist("R8 clear history", 7'h00);
    train("R7 train pc A", 32'h0000_5000, 7'h00, 1);
    train("R7 train pc A", 32'h0000_5000, 7'h00, 1);
    lookup("R7 R11 lookup A taken", 32'h0000_5000);
    lookup("R7 R11 history carries taken", 32'h0000_5100);
    lookup("R7 R11 history carries not-taken", 32'h0000_5200);
    lookup("R7 R11 back-to-back lookups", 32'h0000_5300);
  endtask

  task automatic t_bypass();
    set_hist("R8 set history", 7'h13);
    step("R10 same-entry update forwarded", 1, 32'h0000_6000, 1, 32'h0000_6000, 7'h13, 1, 0);
    set_hist("R8 set history", 7'h13);
    step("R10 second forward saturates", 1, 32'h0000_6000, 1, 32'h0000_6000, 7'h13, 1, 0);
    set_hist("R8 set history", 7'h13);
    step("R10 different entry not forwarded", 1, 32'h0000_6000, 1, 32'h0000_6004, 7'h13, 0, 0);
  endtask

  task automatic t_repair();
    set_hist("R8 set history", 7'h0F);
    step("R8 repair beats lookup shift", 1, 32'h0000_7000, 1, 32'h0000_7700, 7'h46, 1, 1);
    lookup("R8 R11 snapshot after repair", 32'h0000_7000);
    step("R9 plain update with lookup keeps shift", 1, 32'h0000_7010, 1, 32'h0000_7700, 7'h46, 0, 0);
    lookup("R9 R11 history after plain update", 32'h0000_7020);
  endtask

  initial begin
    n_tests = 0; n_fail = 0; done = 0;
    for (int i = 0; i < DEPTH; i++) ref_tbl[i] = 2'b01;
    ref_hist = '0; last_ctr = 2'b00; last_taken = 1'b0; last_hist = '0;
    rst_n = 1'b0; lk_valid = 1'b0; lk_pc = '0; upd_valid = 1'b0; upd_pc = '0;
    upd_hist = '0; upd_taken = 1'b0; upd_mispred = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_latency();
    t_saturate();
    t_hash();
    t_spec();
    t_bypass();
    t_repair();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule